// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps SDRAM contents alive by issuing periodic CAS-before-RAS auto-refresh commands on behalf of a memory controller. A free-running interval counter raises a refresh request each time the programmed interval elapses. The request is held pending until the scheduler takes it. Once taken, the scheduler asserts a busy output so the controller starts no new access.

While busy, the scheduler first lets any access already in flight finish, such as a long ROM burst. It then closes every bank that has an open page, spending two cycles per bank. Next it waits a programmable precharge-to-activate delay and issues one REFRESH command. Busy holds for one more cycle after that command and then drops. The counter reloads on its own expiry, not on service, so a deferred refresh does not push later ones back. A second expiry while a request is still waiting sets a sticky overrun flag.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, `cmd_o` is NOP (0), `cmd_bank_o` is 0, `busy_o` is 0 and `overrun_o` is 0.
- R2: With a nonzero interval N, a request is raised every N cycles and the counter restarts at expiry. When each refresh finishes inside its interval, successive rising edges of `busy_o` are exactly N cycles apart, whatever the earlier access waits were.
- R3: An interval of 0 disables the counter, so no refresh is ever started.
- R4: After a request is taken, no command is issued while `access_busy_i` is high. The first command comes in the cycle after the first busy-taken cycle in which `access_busy_i` was sampled low.
- R5: `bank_open_i` is sampled when the access wait ends. Each bank that is open there gets exactly one PRECHARGE (code 1), in ascending bank order, with `cmd_bank_o` giving the bank index. Each PRECHARGE is followed by one NOP cycle. Closed banks are skipped.
- R6: Let E be the last cycle of the precharge sweep (the NOP after the final PRECHARGE), or the last wait cycle if no bank was open. Let P be `pre_to_act_i`. REFRESH (code 2) is issued in cycle E+1+max(P,1), exactly once per busy window.
- R7: `busy_o` rises in the second cycle after the interval expires, when the scheduler is idle. It stays high through the cycle after REFRESH and is low in the cycle after that.
- R8: `overrun_o` sets when the interval expires while an earlier request is still untaken. It then stays set until reset. It stays 0 while every request is taken before the next expiry.
- R9: Whenever `busy_o` is low, `cmd_o` is NOP and `cmd_bank_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_interval_i | input | INT_W | Refresh interval in cycles; 0 disables |
| pre_to_act_i | input | DLY_W | Precharge-to-activate delay in cycles |
| access_busy_i | input | 1 | A memory or ROM access is in flight |
| bank_open_i | input | NUM_BANKS | One bit per bank with an open page |
| cmd_o | output | 2 | Command: 0 NOP, 1 PRECHARGE, 2 REFRESH |
| cmd_bank_o | output | BANK_W | Bank index for PRECHARGE |
| busy_o | output | 1 | Refresh owns the memory; block new accesses |
| overrun_o | output | 1 | Sticky: an expiry came while a request was pending |

## Verification
The assertions assume the controller honours `busy_o`: once busy is high, `access_busy_i` only falls and does not rise again. They also assume `bank_open_i` describes the banks correctly when the wait ends. The stimulus raises `access_busy_i` only before or at the start of a refresh and drops it once, after a randomly chosen number of cycles. It holds the open-bank mask and delay steady through each refresh. The random hold times and sweep lengths stay well under the interval in the main phase, so deferral never overlaps the next expiry. A dedicated phase then shortens the interval and holds the access to force an overrun.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_REF = 2'd2
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_PRE,
    ST_WAIT,
    ST_REF,
    ST_DONE
  } ref_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] interval_i,
  input  logic             accept_i,
  output logic             pend_o,
  output logic             overrun_o
);
  logic [INT_W-1:0] cnt_q;
  logic             pend_q, ovr_q, tick;

  assign tick = (interval_i != '0) && (cnt_q >= interval_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (interval_i == '0 || tick) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
      pend_q <= (pend_q & ~accept_i) | tick;
      ovr_q  <= ovr_q | (tick & pend_q & ~accept_i);
    end
  end

  assign pend_o    = pend_q;
  assign overrun_o = ovr_q;

  assert_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> (cnt_q == '0));
  assert_disabled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0 && !pend_q) |=> !pend_q);
  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
endmodule

// File: rtl/ref_bank_picker.sv
module ref_bank_picker #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0] mask_i,
  output logic [NUM_BANKS-1:0] sel_o,
  output logic [BANK_W-1:0]    idx_o
);
  // lowest open bank wins
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    if (i == 0) begin : g_first
      assign sel_o[i] = mask_i[i];
    end else begin : g_rest
      assign sel_o[i] = mask_i[i] & ~|mask_i[i-1:0];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (sel_o[i]) idx_o = idx_o | BANK_W'(i);
  end
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_ref_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int INT_W     = 16,
  parameter int DLY_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [INT_W-1:0]     ref_interval_i,
  input  logic [DLY_W-1:0]     pre_to_act_i,
  input  logic                 access_busy_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic [1:0]           cmd_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic                 busy_o,
  output logic                 overrun_o
);
  ref_state_e           state_q, state_d;
  logic [NUM_BANKS-1:0] mask_q, sel;
  logic [BANK_W-1:0]    idx;
  logic [DLY_W-1:0]     dly_q;
  logic                 ph_q, pend, accept;

  assign accept = (state_q == ST_IDLE) & pend;

  ref_interval_timer #(.INT_W(INT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .interval_i(ref_interval_i),
    .accept_i  (accept),
    .pend_o    (pend),
    .overrun_o (overrun_o)
  );

  ref_bank_picker #(.NUM_BANKS(NUM_BANKS)) u_pick (
    .mask_i(mask_q),
    .sel_o (sel),
    .idx_o (idx)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (pend) state_d = ST_DRAIN;
      ST_DRAIN: if (!access_busy_i) state_d = (|bank_open_i) ? ST_PRE : ST_WAIT;
      ST_PRE:   if (ph_q && ((mask_q & ~sel) == '0)) state_d = ST_WAIT;
      ST_WAIT:  if (dly_q <= DLY_W'(1)) state_d = ST_REF;
      ST_REF:   state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      dly_q   <= '0;
      ph_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= (state_q == ST_PRE) ? ~ph_q : 1'b0;
      if (state_q == ST_DRAIN && !access_busy_i) mask_q <= bank_open_i;
      else if (state_q == ST_PRE && ph_q)        mask_q <= mask_q & ~sel;
      if (state_q != ST_WAIT && state_d == ST_WAIT) dly_q <= pre_to_act_i;
      else if (state_q == ST_WAIT && dly_q != '0)   dly_q <= dly_q - 1'b1;
    end
  end

  always_comb begin
    cmd_o      = CMD_NOP;
    cmd_bank_o = '0;
    if (state_q == ST_PRE && !ph_q) begin
      cmd_o      = CMD_PRE;
      cmd_bank_o = idx;
    end else if (state_q == ST_REF) begin
      cmd_o = CMD_REF;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_idle_nop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cmd_o == CMD_NOP && cmd_bank_o == '0));
  assert_pre_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |=> (cmd_o == CMD_NOP));
  assert_pick_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |-> ($onehot(sel) && ((sel & ~mask_q) == '0)));
  assert_drain_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && access_busy_i) |=> (cmd_o == CMD_NOP));
  assert_ref_tail_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |=> (busy_o && cmd_o == CMD_NOP));
  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE) |=> !busy_o);
endmodule

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb;
  localparam int NB = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ref_interval_i = 16'd200;
  logic [3:0]  pre_to_act_i = '0;
  logic        access_busy_i = 1'b0;
  logic [NB-1:0] bank_open_i = '0;
  logic [1:0]  cmd_o;
  logic [1:0]  cmd_bank_o;
  logic        busy_o, overrun_o;

  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  sdram_refresh_sched u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_interval_i(ref_interval_i),
    .pre_to_act_i(pre_to_act_i), .access_busy_i(access_busy_i),
    .bank_open_i(bank_open_i), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o),
    .busy_o(busy_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int nth_bank(input logic [NB-1:0] m, input int j);
    int c = 0;
    for (int b = 0; b < NB; b++)
      if (m[b]) begin
        if (c == j) return b;
        c++;
      end
    return -1;
  endfunction

  function automatic int ref_cycle(input logic [NB-1:0] m, input int p, input int hold);
    int n = $countones(m);
    int e = (n > 0) ? hold + 2 * n : hold;
    return e + 1 + ((p < 1) ? 1 : p);
  endfunction

  // k = 0 is the first cycle with busy_o high
  task automatic do_refresh(input logic [NB-1:0] m, input int p, input int hold,
                            output int rise);
    int n = $countones(m);
    int rk = ref_cycle(m, p, hold);
    int guard = 0;
    bank_open_i   = m;
    pre_to_act_i  = 4'(p);
    access_busy_i = (hold > 0);
    while (!busy_o && guard < 1000) begin
      @(negedge clk_i);
      guard++;
    end
    chk(busy_o, "R7 busy rise", int'(busy_o), 1);
    rise = cyc;
    for (int k = 0; k <= rk + 2; k++) begin
      int ec = 0, eb = 0;
      string tag = "R9";
      if (k <= hold) tag = "R4";
      else if (k <= hold + 2 * n) begin
        tag = "R5";
        if (((k - hold - 1) % 2) == 0) begin
          ec = 1;
          eb = nth_bank(m, (k - hold - 1) / 2);
        end
      end else if (k == rk) begin
        tag = "R6";
        ec = 2;
      end
      chk(int'(cmd_o) == ec && int'(cmd_bank_o) == eb, tag,
          int'(cmd_o) * 16 + int'(cmd_bank_o), ec * 16 + eb);
      chk(busy_o == (k <= rk + 1), "R7 busy window", int'(busy_o), int'(k <= rk + 1));
      access_busy_i = (k < hold);
      @(negedge clk_i);
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int rise, prev_rise;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk(cmd_o == 2'd0 && cmd_bank_o == 2'd0, "R1 cmd in reset", int'(cmd_o), 0);
    chk(!busy_o && !overrun_o, "R1 flags in reset", int'(busy_o) + 2 * int'(overrun_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && cmd_o == 2'd0, "R1 after reset", int'(busy_o), 0);

    // directed corners
    do_refresh(4'b0000, 0, 0, prev_rise);
    do_refresh(4'b1111, 3, 0, rise);
    chk(rise - prev_rise == 200, "R2 period", rise - prev_rise, 200);
    prev_rise = rise;
    do_refresh(4'b1010, 1, 5, rise);
    chk(rise - prev_rise == 200, "R2 period", rise - prev_rise, 200);
    prev_rise = rise;
    do_refresh(4'b0001, 0, 0, rise);
    chk(rise - prev_rise == 200, "R2 period after deferral", rise - prev_rise, 200);
    prev_rise = rise;
    do_refresh(4'b1000, 15, 30, rise);
    chk(rise - prev_rise == 200, "R2 period", rise - prev_rise, 200);
    prev_rise = rise;

    // random mix
    for (int it = 0; it < 24; it++) begin
      do_refresh(NB'($urandom % 16), int'($urandom % 16), int'($urandom % 40), rise);
      chk(rise - prev_rise == 200, "R2 period random", rise - prev_rise, 200);
      chk(!overrun_o, "R8 no false overrun", int'(overrun_o), 0);
      prev_rise = rise;
    end

    // overrun: short interval, access held
    chk(!overrun_o, "R8 clear before", int'(overrun_o), 0);
    access_busy_i  = 1'b1;
    ref_interval_i = 16'd20;
    repeat (100) @(negedge clk_i);
    chk(overrun_o, "R8 overrun set", int'(overrun_o), 1);
    chk(busy_o && cmd_o == 2'd0, "R4 held by access", int'(cmd_o), 0);
    access_busy_i = 1'b0;
    repeat (200) @(negedge clk_i);
    chk(overrun_o, "R8 sticky", int'(overrun_o), 1);

    // disabled interval
    rst_ni = 1'b0;
    ref_interval_i = 16'd0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(!overrun_o && !busy_o, "R1 reset clears overrun", int'(overrun_o), 0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk_i);
        if (busy_o || cmd_o != 2'd0) seen = 1'b1;
      end
      chk(!seen, "R3 interval zero idle", int'(seen), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule